// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Starvation Guard

This block decides which of several bus masters owns the bus at each arbitration event. Normally the choice is a fixed ranking: master 0 wins over master 1, master 1 over master 2, and so on. A pure fixed ranking can starve a low-ranked master indefinitely, so an optional guard watches for masters that have waited across two consecutive sampling windows and lifts them above every normal priority until they are served.

The guard measures time in arbitration events, not clock cycles. A window counter advances on each strobe. The window closes on the strobe that brings the count to the programmed threshold, and the counter then starts again from zero. When a window closes, every master requesting at that moment is marked as waiting. If a marked master is still requesting when the next window closes, it is flagged as starved. Starved masters are granted ahead of all others and are served in their fixed ranking among themselves. Any grant removes both marks from the master that receives it. The threshold is normally programmed to at least the number of masters, and a value of 64 is the usual setting after reset.

Top module: `starve_arbiter`

## Requirements
- R1: During a strobe with no starved requester, the grant goes to the active requester with the lowest index, so master 0 has the highest priority.
- R2: `grant` has at most one bit set. It is all zeros whenever `arb_strobe` is low or no request is active.
- R3: While the guard is enabled, a window closes on every T-th strobe, counting from reset or from the last close. T is `threshold`, and a value of 0 is treated as 1.
- R4: When a window closes, each master requesting on that strobe is marked as waiting, unless that same strobe grants it.
- R5: A grant clears the granted master's waiting mark and starved flag from the next cycle. This holds even on a strobe that closes a window.
- R6: When a window closes, a master that is both marked as waiting and requesting becomes starved. Its `starved` bit is 1 from the next cycle.
- R7: A starved master with an active request is granted ahead of every non-starved master. Among several such masters, the lowest index is granted first.
- R8: While `guard_en` is low, the window counter is held at zero, all marks are cleared, `starved` reads all zeros from the next cycle, and plain fixed priority applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MASTERS | Per-master request lines |
| arb_strobe | input | 1 | One arbitration event in this cycle |
| guard_en | input | 1 | Starvation guard enable |
| threshold | input | 8 | Window length in arbitration events |
| grant | output | N_MASTERS | One-hot grant, valid during the strobe cycle |
| starved | output | N_MASTERS | Per-master starved flag |

## Verification
Two events can fall on the same strobe: a window close and a grant to a master that already carries a waiting mark. The bench provokes this by dropping the higher-ranked request exactly on the closing strobe, so the marked master wins normally at that instant. It then checks that no starved flag appears, which shows the grant took precedence over promotion. A second overlap, where several masters become starved on one close, is judged by the order of the following grants.

// File: rtl/starve_arb_pkg.sv
package starve_arb_pkg;

  localparam int unsigned WIN_CNT_W = 8;
  typedef logic [WIN_CNT_W-1:0] win_cnt_t;

  // A zero threshold would give an empty window; treat it as one event.
  function automatic win_cnt_t eff_threshold(input win_cnt_t thr);
    return (thr == '0) ? win_cnt_t'(1) : thr;
  endfunction

  // True on the strobe that completes the window.
  function automatic logic closes_window(input win_cnt_t cnt, input win_cnt_t thr);
    return cnt >= (eff_threshold(thr) - win_cnt_t'(1));
  endfunction

endpackage

// File: rtl/win_counter.sv
module win_counter
  import starve_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     strobe,
  input  win_cnt_t threshold,
  output logic     window_end
);

  win_cnt_t cnt_q;

  assign window_end = en && strobe && closes_window(cnt_q, threshold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (strobe) begin
      cnt_q <= window_end ? '0 : cnt_q + win_cnt_t'(1);
    end
  end

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (cnt_q == '0));

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  assert_idle_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !strobe) |=> $stable(cnt_q));

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 window_end,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] grant,
  output logic [N_MASTERS-1:0] pending,
  output logic [N_MASTERS-1:0] starved
);

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_master
    logic mark_now;
    logic starve_now;

    assign mark_now   = window_end && req[i];
    assign starve_now = window_end && req[i] && pending[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
        starved[i] <= 1'b0;
      end else if (!en) begin
        pending[i] <= 1'b0;
        starved[i] <= 1'b0;
      end else if (grant[i]) begin
        // A grant wins over a window close in the same cycle.
        pending[i] <= 1'b0;
        starved[i] <= 1'b0;
      end else begin
        if (mark_now)   pending[i] <= 1'b1;
        if (starve_now) starved[i] <= 1'b1;
      end
    end

    assert_grant_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> (!pending[i] && !starved[i]));

    assert_starve_needs_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(starved[i]) |-> ($past(pending[i]) && $past(window_end)));

    assert_mark_on_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && window_end && req[i] && !grant[i]) |=> pending[i]);
  end

  assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (starved == '0 && pending == '0));

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] vec,
  output logic [N_MASTERS-1:0] onehot
);

  always_comb begin
    logic found;
    found  = 1'b0;
    onehot = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (vec[i] && !found) begin
        onehot[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/starve_arbiter.sv
module starve_arbiter
  import starve_arb_pkg::*;
#(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 arb_strobe,
  input  logic                 guard_en,
  input  logic [WIN_CNT_W-1:0] threshold,
  output logic [N_MASTERS-1:0] grant,
  output logic [N_MASTERS-1:0] starved
);

  logic                 window_end;
  logic [N_MASTERS-1:0] pending;
  logic [N_MASTERS-1:0] promoted;
  logic [N_MASTERS-1:0] pick_src;
  logic [N_MASTERS-1:0] pick_out;

  win_counter u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (guard_en),
    .strobe     (arb_strobe),
    .threshold  (threshold),
    .window_end (window_end)
  );

  // Starved requesters form their own tier above the normal ranking.
  assign promoted = starved & req;
  assign pick_src = (|promoted) ? promoted : req;

  prio_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .vec    (pick_src),
    .onehot (pick_out)
  );

  assign grant = arb_strobe ? pick_out : '0;

  flag_bank #(.N_MASTERS(N_MASTERS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (guard_en),
    .window_end (window_end),
    .req        (req),
    .grant      (grant),
    .pending    (pending),
    .starved    (starved)
  );

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (arb_strobe && (|(grant & req))));

  assert_some_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_strobe && (|req)) |-> ($countones(grant) == 1));

  assert_starved_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_strobe && (|promoted)) |-> (|(grant & starved)));

endmodule

// File: tb/sim_starve_arbiter.sv
module sim_starve_arbiter;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         arb_strobe = 1'b0;
  logic         guard_en = 1'b0;
  logic [7:0]   threshold = 8'd4;
  logic [N-1:0] grant;
  logic [N-1:0] starved;

  int n_checks = 0;
  int n_fails  = 0;

  always #5ns clk = ~clk;

  starve_arbiter #(.N_MASTERS(N)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .arb_strobe (arb_strobe),
    .guard_en   (guard_en),
    .threshold  (threshold),
    .grant      (grant),
    .starved    (starved)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic [7:0] thr);
    @(negedge clk);
    rst_n = 1'b0; arb_strobe = 1'b0; req = '0;
    guard_en = en; threshold = thr;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One strobe: drive at negedge, check grant, clock it, drop strobe.
  task automatic arb(input logic [N-1:0] r, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    req = r; arb_strobe = 1'b1;
    #1ns check(tag, grant, exp);
    @(posedge clk);
    #1ns arb_strobe = 1'b0;
  endtask

  task automatic run_n(input int n, input logic [N-1:0] r, input logic [N-1:0] exp, input string tag);
    for (int k = 0; k < n; k++) arb(r, exp, tag);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 8'd4);
    req = 4'b1111;
    #1ns check("R2 no strobe", grant, 4'b0000);
    check("R8 reset starved", starved, 4'b0000);
  endtask

  task automatic t_fixed();
    do_reset(1'b0, 8'd4);
    arb(4'b1010, 4'b0010, "R1 pattern 1010");
    arb(4'b1100, 4'b0100, "R1 pattern 1100");
    arb(4'b1000, 4'b1000, "R1 pattern 1000");
    arb(4'b1111, 4'b0001, "R1 pattern 1111");
    arb(4'b0000, 4'b0000, "R2 no request");
  endtask

  task automatic t_single_starve();
    do_reset(1'b1, 8'd4);
    run_n(7, 4'b1001, 4'b0001, "R1 normal");
    check("R3 no close before 8", starved, 4'b0000);
    arb(4'b1001, 4'b0001, "R1 strobe 8");
    check("R6 starved after second close", starved, 4'b1000);
    arb(4'b1001, 4'b1000, "R7 promoted grant");
    check("R5 starved cleared", starved, 4'b0000);
    arb(4'b1001, 4'b0001, "R5 back to normal");
  endtask

  task automatic t_multi_starve();
    do_reset(1'b1, 8'd4);
    run_n(8, 4'b1110, 4'b0010, "R1 normal");
    check("R4 R6 two starved", starved, 4'b1100);
    arb(4'b1110, 4'b0100, "R7 lower index first");
    check("R5 one left", starved, 4'b1000);
    arb(4'b1110, 4'b1000, "R7 second starved");
    arb(4'b1110, 4'b0010, "R7 normal resumes");
  endtask

  task automatic t_collision();
    do_reset(1'b1, 8'd4);
    run_n(7, 4'b0011, 4'b0001, "R1 normal");
    arb(4'b0010, 4'b0010, "R5 grant on close");
    check("R5 grant beats close", starved, 4'b0000);
    run_n(4, 4'b0011, 4'b0001, "R1 normal");
    check("R4 fresh mark only", starved, 4'b0000);
  endtask

  task automatic t_disable();
    do_reset(1'b1, 8'd4);
    run_n(8, 4'b1001, 4'b0001, "R1 normal");
    check("R6 precondition", starved, 4'b1000);
    @(negedge clk);
    guard_en = 1'b0;
    @(posedge clk);
    #1ns check("R8 flags cleared", starved, 4'b0000);
    arb(4'b1001, 4'b0001, "R8 plain priority");
    @(negedge clk);
    guard_en = 1'b1;
    run_n(7, 4'b1001, 4'b0001, "R8 normal");
    check("R8 counter restarted", starved, 4'b0000);
    arb(4'b1001, 4'b0001, "R3 strobe 8");
    check("R3 starved after full windows", starved, 4'b1000);
  endtask

  task automatic t_zero_thr();
    do_reset(1'b1, 8'd0);
    arb(4'b0011, 4'b0001, "R3 thr0 s1");
    arb(4'b0011, 4'b0001, "R3 thr0 s2");
    check("R3 thr0 acts as 1", starved, 4'b0010);
    arb(4'b0011, 4'b0010, "R7 thr0 promoted");
  endtask

  initial begin
    #2ms;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_single_starve();
    t_multi_starve();
    t_collision();
    t_disable();
    t_zero_thr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule